// File: doc/BRIEF.md
# Automatic Main Clock Source Selector

This block decides which of three reference clocks should drive the application logic. The three candidates are the local oscillator, a clock arriving on an external distribution link, and a clock recovered from the Ethernet receive path. The local oscillator is the default. The selector moves to the link clock on its own, once that clock has run within 1 % of the local frequency for a qualifying period. Two control inputs change this behaviour. One keeps the link clock out of use. The other forces the Ethernet-recovered clock whenever that clock reports lock.

The link clock is seen as a toggling input and is sampled in the local domain. Its rising edges are counted over a gate window of local cycles. The count is scaled so that equal frequencies read 10000, with one unit equal to 100 ppm. This estimate, the two stability flags and the current decision are published in a 32-bit status word. Every change of the decision fires an application reset pulse of fixed length. The glitch-free clock multiplexer and the PLLs sit outside the block and consume `sel_code`.

Top module: `refclk_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, with no link activity and both control inputs low, `sel_code` is 00, `app_rst` is low and `status_word` is all zero.
- R2: At the end of each gate window of `REF_EDGES*TICK_DIV` local cycles, `status_word[31:16]` is loaded with the number of link rising edges seen in that window times `10000/REF_EDGES`, saturating at 65535. A link tick whose period is `TICK_DIV` local cycles therefore reads 10000.
- R3: The link clock is judged stable (`status_word[0]` = 1) only when the estimate has been in the band 9900..10100 for `HOLD_CYCLES` consecutive cycles. The link clock is never selected before that.
- R4: A link clock whose estimate lies outside 9900..10100 is never marked stable and never selected.
- R5: With `link_inhibit` high and `force_eth` low, `sel_code` is 00 (local) even when the link is stable. `status_word[0]` still reports link stability.
- R6: With `force_eth` high, `sel_code` is 10 (Ethernet) while `eth_locked` is high and 00 (local) while it is low, whatever the state of the link.
- R7: `status_word[3:2]` equals `sel_code` (00 local, 01 link, 10 Ethernet). `status_word[1]` reports the synchronised `eth_locked`. `status_word[15:4]` is zero.
- R8: Each change of `sel_code` raises `app_rst` in the same cycle, and it stays high for exactly `RST_LEN` cycles after the last change.
- R9: When the link clock stops toggling, it loses its stable flag at the end of the next gate window. A selection of the link then falls back to local, with a reset pulse.
- R10: `sel_code` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_tick | input | 1 | Toggling image of the distribution-link clock, asynchronous |
| eth_locked | input | 1 | Ethernet-recovered clock lock indication, asynchronous |
| link_inhibit | input | 1 | Keeps the link clock out of use when high |
| force_eth | input | 1 | Forces the Ethernet-recovered clock when high |
| sel_code | output | 2 | Chosen source: 00 local, 01 link, 10 Ethernet |
| status_word | output | 32 | {estimate[15:0], 12'b0, sel_code, eth stable, link stable} |
| app_rst | output | 1 | Application reset pulse after each source change |

## Verification
The bench builds the selector with `REF_EDGES=100`, `TICK_DIV=4`, `HOLD_CYCLES=1000` and `RST_LEN=16`. A gate window is then 400 cycles, and one edge more or fewer moves the estimate by exactly the 1 % tolerance. A tick period of 4 cycles reads exactly 10000, and a period of 5 reads exactly 8000, so the estimate can be compared against exact values. The short hold time makes it possible to sample both sides of the qualifying window: still local after 1000 cycles of a good link, linked well after it. There is also room to exercise inhibit, forcing, link loss and off-frequency links within one run.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

    typedef enum logic [1:0] {
        SRC_LOCAL = 2'b00,
        SRC_LINK  = 2'b01,
        SRC_ETH   = 2'b10,
        SRC_BAD   = 2'b11
    } src_e;

    localparam int unsigned EST_W     = 16;
    localparam int unsigned EST_UNITY = 10000;
    localparam int unsigned EST_TOL   = 100;   // 1 % in 100 ppm units

endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/refclk_freq_meter.sv
module refclk_freq_meter
    import refclk_pkg::*;
#(
    parameter int unsigned REF_EDGES = 10000,
    parameter int unsigned TICK_DIV  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_s,
    output logic [EST_W-1:0] est,
    output logic             est_stb
);
    localparam int unsigned GATE_LEN = REF_EDGES * TICK_DIV;
    localparam int unsigned WIN_W    = $clog2(GATE_LEN);
    localparam int unsigned EDGE_W   = $clog2(GATE_LEN + 1);
    localparam int unsigned UNIT     = EST_UNITY / REF_EDGES;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(GATE_LEN - 1);

    typedef struct packed {
        logic              prev;
        logic [WIN_W-1:0]  win;
        logic [EDGE_W-1:0] edges;
        logic [EST_W-1:0]  est;
        logic              stb;
    } meter_t;

    meter_t st_d, st_q;
    logic              rise;
    logic [EDGE_W-1:0] total;
    logic [31:0]       scaled;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        st_d.prev = tick_s;
        rise   = tick_s & ~st_q.prev;
        total  = st_q.edges + EDGE_W'(rise);
        scaled = 32'(total) * 32'(UNIT);
        if (st_q.win == WIN_LAST) begin
            st_d.win   = '0;
            st_d.edges = '0;
            st_d.stb   = 1'b1;
            st_d.est   = (scaled > 32'h0000_FFFF) ? '1 : scaled[EST_W-1:0];
        end else begin
            st_d.win   = st_q.win + 1'b1;
            st_d.edges = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign est     = st_q.est;
    assign est_stb = st_q.stb;
endmodule

// File: rtl/refclk_hold_timer.sv
module refclk_hold_timer
    import refclk_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 20000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EST_W-1:0] est,
    input  logic             est_stb,
    output logic             stable
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYCLES);
    localparam logic [EST_W-1:0] LO = EST_W'(EST_UNITY - EST_TOL);
    localparam logic [EST_W-1:0] HI = EST_W'(EST_UNITY + EST_TOL);

    typedef struct packed {
        logic             in_rng;
        logic [CNT_W-1:0] cnt;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (est_stb) st_d.in_rng = (est >= LO) && (est <= HI);
        if (!st_d.in_rng)            st_d.cnt = '0;
        else if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stable = (st_q.cnt == CNT_MAX);
endmodule

// File: rtl/refclk_rst_pulse.sv
module refclk_rst_pulse #(
    parameter int unsigned RST_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int unsigned CNT_W = $clog2(RST_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig)               st_d.cnt = CNT_W'(RST_LEN);
        else if (st_q.cnt != 0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = (st_q.cnt != '0);
endmodule

// File: rtl/refclk_arbiter.sv
module refclk_arbiter
    import refclk_pkg::*;
#(
    parameter int unsigned REF_EDGES   = 10000,
    parameter int unsigned TICK_DIV    = 4,
    parameter int unsigned HOLD_CYCLES = 20000000,
    parameter int unsigned RST_LEN     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_tick,
    input  logic        eth_locked,
    input  logic        link_inhibit,
    input  logic        force_eth,
    output logic [1:0]  sel_code,
    output logic [31:0] status_word,
    output logic        app_rst
);
    if (RST_LEN < 16)                 $error("RST_LEN must be at least 16");
    if (EST_UNITY % REF_EDGES != 0)   $error("REF_EDGES must divide 10000");

    typedef struct packed {
        src_e sel;
    } arb_t;

    arb_t st_d, st_q;

    logic [1:0]       sync_o;
    logic             tick_s, eth_s;
    logic [EST_W-1:0] est;
    logic             est_stb, link_stable, change;

    refclk_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({eth_locked, link_tick}),
        .sync_out(sync_o)
    );
    assign tick_s = sync_o[0];
    assign eth_s  = sync_o[1];

    refclk_freq_meter #(.REF_EDGES(REF_EDGES), .TICK_DIV(TICK_DIV)) u_meter (
        .clk(clk), .rst_n(rst_n), .tick_s(tick_s),
        .est(est), .est_stb(est_stb)
    );

    refclk_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .est(est), .est_stb(est_stb),
        .stable(link_stable)
    );

    always_comb begin
        st_d = st_q;
        if (force_eth)
            st_d.sel = eth_s ? SRC_ETH : SRC_LOCAL;
        else if (link_inhibit)
            st_d.sel = SRC_LOCAL;
        else
            st_d.sel = link_stable ? SRC_LINK : SRC_LOCAL;
        change = (st_d.sel != st_q.sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: SRC_LOCAL};
        else        st_q <= st_d;
    end

    refclk_rst_pulse #(.RST_LEN(RST_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trig(change), .pulse(app_rst)
    );

    assign sel_code    = st_q.sel;
    assign status_word = {est, 12'h000, st_q.sel, eth_s, link_stable};
endmodule

// File: rtl/refclk_arbiter_chk.sv
module refclk_arbiter_chk #(
    parameter int unsigned RST_LEN = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        force_eth,
    input logic        link_inhibit,
    input logic [1:0]  sel_code,
    input logic [31:0] status_word,
    input logic        app_rst
);
    logic [1:0]  sel_prev;
    int unsigned hi_q;
    logic        chg;

    assign chg = (sel_code != sel_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_prev <= 2'b00;
            hi_q     <= 0;
        end else begin
            sel_prev <= sel_code;
            if (chg)          hi_q <= 1;
            else if (app_rst) hi_q <= hi_q + 1;
            else              hi_q <= 0;
        end
    end

    a_r10_no_invalid_code: assert property (@(posedge clk) disable iff (!rst_n)
        sel_code != 2'b11);

    a_r8_change_fires_reset: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> app_rst);

    a_r8_pulse_not_too_long: assert property (@(posedge clk) disable iff (!rst_n)
        (app_rst && !chg) |-> (hi_q < RST_LEN));

    a_r8_pulse_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(app_rst) |-> (hi_q == RST_LEN));

    a_r3_link_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 2'b01) |-> ($past(status_word[0]) && $past(!link_inhibit) && $past(!force_eth)));

    a_r6_eth_needs_force: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 2'b10) |-> ($past(force_eth) && $past(status_word[1])));

    a_r7_status_mirrors_sel: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[3:2] == sel_code);
endmodule

bind refclk_arbiter refclk_arbiter_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .force_eth(force_eth), .link_inhibit(link_inhibit),
    .sel_code(sel_code), .status_word(status_word), .app_rst(app_rst)
);

// File: tb/tb_refclk_arbiter.sv
`timescale 1ns/1ps
module tb_refclk_arbiter;
    localparam int unsigned HOLD = 1000;
    localparam int unsigned RLEN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_tick = 1'b0;
    logic eth_locked = 1'b0;
    logic link_inhibit = 1'b0;
    logic force_eth = 1'b0;
    logic [1:0]  sel_code;
    logic [31:0] status_word;
    logic        app_rst;

    int checks = 0;
    int fails  = 0;
    int link_period = 0;
    int pulses = 0;
    int cur_len = 0;
    int last_len = 0;
    int bad_codes = 0;
    logic prev_rst = 1'b0;

    always #2 clk = ~clk;

    refclk_arbiter #(.REF_EDGES(100), .TICK_DIV(4), .HOLD_CYCLES(HOLD), .RST_LEN(RLEN)) dut (
        .clk(clk), .rst_n(rst_n), .link_tick(link_tick), .eth_locked(eth_locked),
        .link_inhibit(link_inhibit), .force_eth(force_eth),
        .sel_code(sel_code), .status_word(status_word), .app_rst(app_rst)
    );

    // link tick driver
    initial begin
        forever begin
            if (link_period == 0) begin
                link_tick = 1'b0;
                @(negedge clk);
            end else begin
                link_tick = 1'b1;
                repeat ((link_period + 1) / 2) @(negedge clk);
                link_tick = 1'b0;
                repeat (link_period / 2) @(negedge clk);
            end
        end
    end

    // pulse monitor
    always @(negedge clk) begin
        if (sel_code == 2'b11) bad_codes++;
        if (app_rst && !prev_rst) begin pulses++; cur_len = 1; end
        else if (app_rst) cur_len++;
        if (!app_rst && prev_rst) last_len = cur_len;
        prev_rst = app_rst;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk("R1 sel during reset", {30'd0, sel_code}, 0);
        chk("R1 app_rst during reset", {31'd0, app_rst}, 0);
        rst_n = 1'b1;
        wait_cyc(10);
        chk("R1 sel after reset", {30'd0, sel_code}, 0);
        chk("R1 app_rst after reset", {31'd0, app_rst}, 0);
        chk("R1 status after reset", status_word, 0);
    endtask

    task automatic t_force_eth();
        int p0;
        p0 = pulses;
        force_eth = 1'b1;
        wait_cyc(10);
        chk("R6 forced, eth unlocked stays local", {30'd0, sel_code}, 0);
        eth_locked = 1'b1;
        wait_cyc(30);
        chk("R6 forced, eth locked", {30'd0, sel_code}, 2);
        chk("R7 status sel field eth", {30'd0, status_word[3:2]}, 2);
        chk("R7 status eth stable", {31'd0, status_word[1]}, 1);
        chk("R8 one pulse on eth select", pulses - p0, 1);
        chk("R8 pulse length", last_len, RLEN);
        eth_locked = 1'b0;
        wait_cyc(30);
        chk("R6 forced, eth lost", {30'd0, sel_code}, 0);
        chk("R7 status eth flag cleared", {31'd0, status_word[1]}, 0);
        chk("R8 pulse on fall back", pulses - p0, 2);
        force_eth = 1'b0;
        wait_cyc(5);
    endtask

    task automatic t_link_qualify();
        int p0;
        p0 = pulses;
        link_period = 4;
        wait_cyc(HOLD);
        chk("R3 not selected before hold time", {30'd0, sel_code}, 0);
        chk("R3 not stable before hold time", {31'd0, status_word[0]}, 0);
        wait_cyc(2000);
        chk("R3 link selected after hold", {30'd0, sel_code}, 1);
        chk("R3 link stable flag", {31'd0, status_word[0]}, 1);
        chk("R2 estimate at equal frequency", {16'd0, status_word[31:16]}, 10000);
        chk("R7 reserved status bits zero", {20'd0, status_word[15:4]}, 0);
        chk("R8 pulse on link select", pulses - p0, 1);
        chk("R8 pulse length link", last_len, RLEN);
    endtask

    task automatic t_inhibit();
        link_inhibit = 1'b1;
        wait_cyc(30);
        chk("R5 inhibit forces local", {30'd0, sel_code}, 0);
        chk("R5 link stability still reported", {31'd0, status_word[0]}, 1);
        link_inhibit = 1'b0;
        wait_cyc(30);
        chk("R5 release returns to link", {30'd0, sel_code}, 1);
    endtask

    task automatic t_force_over_link();
        force_eth = 1'b1;
        eth_locked = 1'b1;
        wait_cyc(30);
        chk("R6 force overrides stable link", {30'd0, sel_code}, 2);
        eth_locked = 1'b0;
        wait_cyc(30);
        chk("R6 forced without eth lock ignores link", {30'd0, sel_code}, 0);
        force_eth = 1'b0;
        wait_cyc(30);
        chk("R6 back to link", {30'd0, sel_code}, 1);
    endtask

    task automatic t_loss();
        int p0;
        p0 = pulses;
        link_period = 0;
        wait_cyc(1000);
        chk("R9 fall back to local on loss", {30'd0, sel_code}, 0);
        chk("R9 stable flag cleared", {31'd0, status_word[0]}, 0);
        chk("R2 estimate with no edges", {16'd0, status_word[31:16]}, 0);
        chk("R9 pulse on loss", pulses - p0, 1);
    endtask

    task automatic t_off_freq();
        int p0;
        p0 = pulses;
        link_period = 5;
        wait_cyc(1000);
        chk("R2 estimate at 0.8 ratio", {16'd0, status_word[31:16]}, 8000);
        wait_cyc(3000);
        chk("R4 slow link not selected", {30'd0, sel_code}, 0);
        chk("R4 slow link not stable", {31'd0, status_word[0]}, 0);
        link_period = 3;
        wait_cyc(4000);
        chk("R4 fast link not selected", {30'd0, sel_code}, 0);
        chk("R4 fast link not stable", {31'd0, status_word[0]}, 0);
        chk("R4 no pulses off frequency", pulses - p0, 0);
    endtask

    initial begin
        t_reset();
        t_force_eth();
        t_link_qualify();
        t_inhibit();
        t_force_over_link();
        t_loss();
        t_off_freq();
        chk("R10 never code 11", bad_codes, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule